// File: doc/BRIEF.md
# Frequency Watchdog with Safe-Code Fallback

This block watches over a programmable clock frequency setting. Software that raises the frequency arms a countdown measured in whole seconds. It then has to keep restarting that countdown, either by pulsing a kick input or by rewriting the timeout value. If the software stops doing so, for example because the raised frequency has made the system unstable, the countdown runs out. The block then latches a trip flag and drives a stored safe frequency code onto its active-code output.

The block also chooses where the active frequency code comes from. It can pass the code latched from pins or set in the basic register, or it can pass the code held in the fine-programmed divider registers. A trip overrides that choice and forces the safe code. The override lasts until software clears the enable bit. A host-side register decoder, which is not part of this block, presents single-cycle writes to the two 8-bit registers. A one-second timebase supplies a single-cycle tick.

Top module: `freq_watchdog`

## Requirements
- R1: After reset, the control readback is 0x00 and the timeout readback is 0xFF. The trip output is low, the fine-source output is low, and the active code equals `pin_code`.
- R2: The control register layout is: bit 7 selects the source, bit 6 enables the watchdog, bit 5 is the trip status and bits [4:0] hold the safe code. A host write updates bits 7, 6 and 4:0. The value written to bit 5 has no effect on it.
- R3: While not tripped, control bit 7 = 0 selects `pin_code` and drives `use_fine_src` low. Control bit 7 = 1 selects `fine_code` and drives `use_fine_src` high.
- R4: While enabled, the countdown drops by one only in cycles where `tick_1hz` is high.
- R5: Suppose the timeout value is N > 0 and the watchdog is enabled with the countdown freshly loaded. Then the trip output and control bit 5 rise on the clock edge one cycle after the edge that takes the N-th tick, and not before.
- R6: A host write to the timeout register (address 1) changes its readback and reloads the countdown with the written value. A timeout of 0 trips on the second edge after the watchdog becomes enabled.
- R7: A `kick` pulse reloads the countdown with the stored timeout value. A write to the timeout register in the same cycle takes precedence.
- R8: While tripped, the active code equals control bits [4:0] and `use_fine_src` is low, whatever bit 7 holds. The trip status stays set through kicks, ticks, timeout writes and control writes that keep bit 6 high.
- R9: A control write with bit 6 = 0 clears the trip status at that edge. This restores the selection given by R3.
- R10: While disabled, the block never trips and the countdown follows the timeout value. After enabling, a full N ticks are needed to trip, however many ticks arrived while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Single-cycle register write strobe |
| host_addr | input | 1 | 0 = control register, 1 = timeout register |
| host_wdata | input | 8 | Write data |
| kick | input | 1 | Countdown restart pulse |
| tick_1hz | input | 1 | One-cycle pulse each second |
| pin_code | input | 5 | Pin-latched or basic-register frequency code |
| fine_code | input | 5 | Fine-programmed divider frequency code |
| ctrl_rdata | output | 8 | Control register readback, status in bit 5 |
| count_rdata | output | 8 | Timeout register readback |
| wd_tripped | output | 1 | Trip status |
| use_fine_src | output | 1 | High when the fine-programmed source is in use |
| active_code | output | 5 | Frequency code in force |

## Verification
The bench counts ticks exactly to the expiry edge. It checks that the trip appears one cycle after the N-th tick, so a design that fires a tick early or a cycle late fails. It tests a zero timeout, ticks arriving while the watchdog is disabled, and a kick issued in the same cycle as a timeout write. A counter that keeps running while disabled, or that lets the wrong reload source win, shows a trip in the wrong cycle. After a trip, the bench flips the source bit and rewrites the status bit. This exposes a status that software can clear directly, and a design that lets the fine source through during a trip. Random operation sequences are then compared, cycle by cycle, against a bench model of the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Host register addresses.
  typedef enum logic {
    REG_CTRL  = 1'b0,
    REG_COUNT = 1'b1
  } wdt_reg_e;

  // What the countdown does in a given cycle, in priority order.
  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_LOAD   = 2'd1,
    CNT_RELOAD = 2'd2,
    CNT_DEC    = 2'd3
  } cnt_op_e;

  function automatic cnt_op_e pick_cnt_op(input logic wr_count, input logic kick,
                                          input logic enabled, input logic tick);
    if (wr_count)        return CNT_LOAD;
    else if (kick)       return CNT_RELOAD;
    else if (!enabled)   return CNT_RELOAD;
    else if (tick)       return CNT_DEC;
    else                 return CNT_HOLD;
  endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
  parameter int CODE_W = 5,
  localparam int CTRL_W   = CODE_W + 3,
  localparam int STAT_BIT = CODE_W,
  localparam int EN_BIT   = CODE_W + 1,
  localparam int SRC_BIT  = CODE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              expire_evt,
  output logic              en_q,
  output logic              src_fine_q,
  output logic              status_q,
  output logic [CODE_W-1:0] safe_code_q,
  output logic [CTRL_W-1:0] rdata
);

  // Host write that turns the watchdog off: the only way to clear status.
  logic disable_wr;
  assign disable_wr = wr_ctrl && !wdata[EN_BIT];

  function automatic logic next_status(input logic cur, input logic evt,
                                       input logic dis);
    return dis ? 1'b0 : (cur | evt);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      src_fine_q  <= 1'b0;
      status_q    <= 1'b0;
      safe_code_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q        <= wdata[EN_BIT];
        src_fine_q  <= wdata[SRC_BIT];
        safe_code_q <= wdata[CODE_W-1:0];
      end
      status_q <= next_status(status_q, expire_evt, disable_wr);
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[SRC_BIT]       = src_fine_q;
    rdata[EN_BIT]        = en_q;
    rdata[STAT_BIT]      = status_q;
    rdata[CODE_W-1:0]    = safe_code_q;
  end

  // R9
  status_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !status_q);

  // R5
  expiry_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !disable_wr) |=> status_q);

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !disable_wr) |=> status_q);

  // R2
  status_not_host_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && !expire_evt) |=> !status_q);

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam logic [CNT_W-1:0] CNT_RESET = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_count,
  input  logic [CNT_W-1:0] wdata,
  input  logic             kick,
  input  logic             enabled,
  input  logic             tick,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] remain_q,
  output logic             at_zero
);

  cnt_op_e op;

  function automatic logic [CNT_W-1:0] dec_floor(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  assign op      = pick_cnt_op(wr_count, kick, enabled, tick);
  assign at_zero = (remain_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= CNT_RESET;
    end else if (wr_count) begin
      count_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= CNT_RESET;
    end else begin
      unique case (op)
        CNT_LOAD:   remain_q <= wdata;
        CNT_RELOAD: remain_q <= count_q;
        CNT_DEC:    remain_q <= dec_floor(remain_q);
        default:    remain_q <= remain_q;
      endcase
    end
  end

  // R4
  tick_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && tick && !wr_count && !kick && !at_zero)
      |=> remain_q == $past(remain_q) - 1'b1);

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !tick && !wr_count && !kick) |=> $stable(remain_q));

  // R10
  disabled_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> remain_q == count_q);

  // R7
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !wr_count) |=> remain_q == count_q);

  // R6
  write_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (remain_q == $past(wdata)) && (count_q == $past(wdata)));

endmodule

// File: rtl/wdt_code_sel.sv
module wdt_code_sel #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tripped,
  input  logic              src_fine,
  input  logic [CODE_W-1:0] safe_code,
  input  logic [CODE_W-1:0] pin_code,
  input  logic [CODE_W-1:0] fine_code,
  output logic              use_fine,
  output logic [CODE_W-1:0] active_code
);

  function automatic logic [CODE_W-1:0] choose_code(
      input logic trip, input logic fine_sel,
      input logic [CODE_W-1:0] safe, input logic [CODE_W-1:0] pin,
      input logic [CODE_W-1:0] fine);
    if (trip)          return safe;
    else if (fine_sel) return fine;
    else               return pin;
  endfunction

  assign use_fine    = src_fine && !tripped;
  assign active_code = choose_code(tripped, src_fine, safe_code, pin_code, fine_code);

  // R8
  trip_forces_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> (active_code == safe_code) && !use_fine);

  // R3
  pin_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tripped && !src_fine) |-> (active_code == pin_code) && !use_fine);

  // R3
  fine_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tripped && src_fine) |-> (active_code == fine_code) && use_fine);

endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 5,
  localparam int CTRL_W = CODE_W + 3,
  localparam int DATA_W = (CNT_W > CTRL_W) ? CNT_W : CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              kick,
  input  logic              tick_1hz,
  input  logic [CODE_W-1:0] pin_code,
  input  logic [CODE_W-1:0] fine_code,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic [CNT_W-1:0]  count_rdata,
  output logic              wd_tripped,
  output logic              use_fine_src,
  output logic [CODE_W-1:0] active_code
);

  // Named internal events, visible to the assertions.
  logic              wr_ctrl;
  logic              wr_count;
  logic              en_q;
  logic              src_fine_q;
  logic              status_q;
  logic [CODE_W-1:0] safe_code_q;
  logic [CNT_W-1:0]  remain_q;
  logic              at_zero;
  logic              expire_evt;

  assign wr_ctrl    = host_wr && (wdt_reg_e'(host_addr) == REG_CTRL);
  assign wr_count   = host_wr && (wdt_reg_e'(host_addr) == REG_COUNT);
  assign expire_evt = en_q && at_zero && !status_q;

  wdt_ctrl_reg #(.CODE_W(CODE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wdata       (host_wdata[CTRL_W-1:0]),
    .expire_evt  (expire_evt),
    .en_q        (en_q),
    .src_fine_q  (src_fine_q),
    .status_q    (status_q),
    .safe_code_q (safe_code_q),
    .rdata       (ctrl_rdata)
  );

  wdt_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_count (wr_count),
    .wdata    (host_wdata[CNT_W-1:0]),
    .kick     (kick),
    .enabled  (en_q),
    .tick     (tick_1hz),
    .count_q  (count_rdata),
    .remain_q (remain_q),
    .at_zero  (at_zero)
  );

  wdt_code_sel #(.CODE_W(CODE_W)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .tripped     (status_q),
    .src_fine    (src_fine_q),
    .safe_code   (safe_code_q),
    .pin_code    (pin_code),
    .fine_code   (fine_code),
    .use_fine    (use_fine_src),
    .active_code (active_code)
  );

  assign wd_tripped = status_q;

  // R10
  no_trip_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(en_q));

  // R5
  trip_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(at_zero));

endmodule

// File: tb/test_freq_watchdog.sv
module test_freq_watchdog;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_addr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       kick = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [4:0] pin_code = 5'd3;
  logic [4:0] fine_code = 5'd17;
  logic [7:0] ctrl_rdata;
  logic [7:0] count_rdata;
  logic       wd_tripped;
  logic       use_fine_src;
  logic [4:0] active_code;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_watchdog i_freq_watchdog (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .kick(kick), .tick_1hz(tick_1hz),
    .pin_code(pin_code), .fine_code(fine_code), .ctrl_rdata(ctrl_rdata),
    .count_rdata(count_rdata), .wd_tripped(wd_tripped),
    .use_fine_src(use_fine_src), .active_code(active_code)
  );

  // Reference model built from the requirements.
  logic       m_src, m_en, m_st;
  logic [4:0] m_safe;
  logic [7:0] m_tout, m_left;

  always @(posedge clk) begin
    logic fire;
    if (!rst_n) begin
      m_src = 0; m_en = 0; m_st = 0; m_safe = 0; m_tout = 8'hFF; m_left = 8'hFF;
    end else begin
      fire = m_en && (m_left == 0) && !m_st;
      // countdown (R4, R6, R7, R10)
      if (host_wr && host_addr)      m_left = host_wdata;
      else if (kick || !m_en)        m_left = m_tout;
      else if (tick_1hz && m_left != 0) m_left = m_left - 8'd1;
      if (host_wr && host_addr) m_tout = host_wdata;
      // status (R5, R8, R9)
      if (fire) m_st = 1;
      if (host_wr && !host_addr) begin
        if (!host_wdata[6]) m_st = 0;
        m_src = host_wdata[7]; m_en = host_wdata[6]; m_safe = host_wdata[4:0];
      end
    end
  end

  function automatic logic [4:0] want_code();
    if (m_st) return m_safe;
    return m_src ? fine_code : pin_code;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_model();
    check("R2 ctrl readback", ctrl_rdata, {m_src, m_en, m_st, m_safe});
    check("R6 count readback", count_rdata, m_tout);
    check("R5 trip", wd_tripped, m_st);
    check("R3 source", use_fine_src, m_src && !m_st);
    check("R8 code", active_code, want_code());
  endtask

  // One cycle: drive at the falling edge, compare the settled outputs.
  task automatic step(input logic wr, input logic addr, input logic [7:0] d,
                      input logic k, input logic t);
    @(negedge clk);
    host_wr = wr; host_addr = addr; host_wdata = d; kick = k; tick_1hz = t;
    #1 check_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset values
    check("R1 ctrl", ctrl_rdata, 8'h00);
    check("R1 count", count_rdata, 8'hFF);
    check("R1 trip", wd_tripped, 1'b0);
    check("R1 fine", use_fine_src, 1'b0);
    check("R1 code", active_code, pin_code);

    // R2, R3: fine source, bit5 written as 1 is ignored
    step(1, 0, 8'hA9, 0, 0);
    step(0, 0, 8'h00, 0, 0);
    check("R2 bit5 ignored", ctrl_rdata, 8'h89);
    check("R3 fine code", active_code, 5'd17);
    check("R3 fine flag", use_fine_src, 1'b1);

    // R10: ticks while disabled do nothing
    step(1, 1, 8'd3, 0, 0);
    ticks(6);
    check("R10 no trip disabled", wd_tripped, 1'b0);

    // R5: enable with timeout 3, trip one cycle after third tick
    step(1, 0, 8'hC9, 0, 0);      // src=1, en=1, safe=9
    step(0, 0, 8'h00, 0, 0);
    ticks(2);
    idle(1);
    check("R5 not yet after 2 ticks", wd_tripped, 1'b0);
    ticks(1);
    idle(1);
    check("R5 not yet at tick edge", wd_tripped, 1'b0);
    idle(1);
    check("R5 trip rises", wd_tripped, 1'b1);
    check("R8 safe code", active_code, 5'd9);
    check("R8 source forced", use_fine_src, 1'b0);
    check("R2 status readback", ctrl_rdata, 8'hE9);

    // R8 sticky through kick, count write, enabled ctrl write with bit5=0
    step(0, 0, 8'h00, 1, 0);
    step(1, 1, 8'd5, 0, 1);
    step(1, 0, 8'hC4, 0, 0);
    idle(2);
    check("R8 sticky", wd_tripped, 1'b1);
    check("R8 new safe", active_code, 5'd4);

    // R9 clear by disabling
    step(1, 0, 8'h80, 0, 0);
    idle(1);
    check("R9 cleared", wd_tripped, 1'b0);
    check("R9 fine restored", active_code, fine_code);

    // R6 zero timeout trips on second edge after enabling
    step(1, 1, 8'd0, 0, 0);
    step(1, 0, 8'h41, 0, 0);
    idle(1);
    check("R6 zero not at first edge", wd_tripped, 1'b0);
    idle(1);
    check("R6 zero trips", wd_tripped, 1'b1);
    step(1, 0, 8'h00, 0, 0);

    // R7 kick restarts, write wins over kick in same cycle
    step(1, 1, 8'd2, 0, 0);
    step(1, 0, 8'h40, 0, 0);
    ticks(1);
    step(0, 0, 8'h00, 1, 0);      // reload to 2
    ticks(1);
    idle(2);
    check("R7 kick delayed trip", wd_tripped, 1'b0);
    step(1, 1, 8'd4, 1, 0);       // write 4 with kick
    ticks(3);
    idle(2);
    check("R7 write beats kick", wd_tripped, 1'b0);
    ticks(1);
    idle(2);
    check("R4 trip after fourth tick", wd_tripped, 1'b1);
    step(1, 0, 8'h00, 0, 0);

    // Random mix compared with the model every cycle (R2..R10)
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = $urandom % 8;
      if ($urandom % 16 == 0) begin pin_code = 5'($urandom); fine_code = 5'($urandom); end
      case (op)
        0: step(1, 0, 8'($urandom) | (($urandom % 4 != 0) ? 8'h40 : 8'h00), 0, 0);
        1: step(1, 1, 8'($urandom % 4), 0, 0);
        2: step(0, 0, 8'h00, 1, $urandom % 2 == 1);
        3, 4, 5: step(0, 0, 8'h00, 0, 1);
        default: step(0, 0, 8'h00, 0, 0);
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule